// File: doc/BRIEF.md
# Calibration Start Qualifier

This block decides when a converter calibration sequence may begin and raises a running flag for the whole sequence. A calibration request comes from an external pin. In extended-control mode it can also come from a register bit. The request must show a clean low interval and then a clean high interval, each counted in input clock cycles, before a sequence starts. A single glitch or a short pulse on the pin therefore cannot begin a calibration.

After reset the block runs one power-on calibration. It waits for the power-good indication, then counts one of two selectable delays, and only then starts. The sequence itself is the same no matter what started it: a fixed number of cycles with the running flag high. While a sequence runs, all requests are ignored. Arming starts again only with a low interval that begins after the flag has dropped.

Top module: `cal_start_qualifier`

## Requirements
- R1: A start is armed only after the effective request has been sampled low on at least LOW_MIN consecutive clock edges. If the request rises after fewer low edges, no calibration starts while it stays high.
- R2: Once armed, the request must be sampled high on HIGH_MIN consecutive edges, and `calRunning` rises right after the last of these edges. If the request drops low before then, the arming is lost, and a full new low interval is needed before another start.
- R3: The effective request is `calPin` OR `calBit` when `extMode` is 1, and `calPin` alone when `extMode` is 0. In the second case `calBit` has no effect.
- R4: `calRunning` stays high for exactly RUN_CYCLES clock cycles and then returns low, whatever started the sequence.
- R5: While `calRunning` is high, changes on the request are ignored. Low cycles seen during a run do not count toward the next arming.
- R6: In extended-control mode, a `calBit` held at 1 keeps the effective request high. Toggling the pin then starts nothing until both the pin and the bit are low.
- R7: After reset, one calibration starts after `powerGood` has been high for PON_SHORT edges (when `ponDelaySel` is 0) or PON_LONG edges (when it is 1). The power-on calibration does not repeat.
- R8: While `rstN` is low, `calRunning` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sampling clock; all durations are counted on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| calPin | input | 1 | External calibration request level |
| calBit | input | 1 | Register calibration request level, used only in extended-control mode |
| extMode | input | 1 | 1 selects extended-control mode (pin OR bit) |
| powerGood | input | 1 | Supply-valid indication; the power-on delay counts while it is 1 |
| ponDelaySel | input | 1 | 0 selects the short power-on delay, 1 the long one |
| calRunning | output | 1 | High while a calibration sequence is in progress |

## Verification
The hardest case to reach from the ports is an arming that is broken partway. The request has to complete a valid low interval, then drop during the high interval one cycle short of the start, and after that the block must demand a full new low interval. The stimulus holds each level for a precise number of edges, one below and exactly at each threshold. It also holds the pin low during a run to show that those cycles never count toward arming. For the extended-control case, the register bit is held high while the pin goes through a complete, otherwise valid, low-then-high sequence.

// File: rtl/cal_qual_pkg.sv
package cal_qual_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LOW,
    ST_WAIT_HIGH,
    ST_RUN,
    ST_PON_DELAY
  } calState_t;

  // strobes from the sequencer to the interval counter
  typedef struct packed {
    logic cntClear;
    logic cntLoadOne;
    logic cntInc;
  } cntCtl_t;

endpackage

// File: rtl/cal_qual_count.sv
module cal_qual_count
  import cal_qual_pkg::*;
#(
  parameter int LOW_MIN    = 4,
  parameter int HIGH_MIN   = 3,
  parameter int RUN_CYCLES = 10,
  parameter int PON_SHORT  = 5,
  parameter int PON_LONG   = 12
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t ctl,
  input  logic    calPin,
  input  logic    calBit,
  input  logic    extMode,
  input  logic    ponDelaySel,
  output logic    reqEff,
  output logic    lowMet,
  output logic    highMet,
  output logic    runDone,
  output logic    ponDone
);

  localparam int MAX_A  = (LOW_MIN > HIGH_MIN) ? LOW_MIN : HIGH_MIN;
  localparam int MAX_B  = (RUN_CYCLES > PON_SHORT) ? RUN_CYCLES : PON_SHORT;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_V  = (MAX_C > PON_LONG) ? MAX_C : PON_LONG;
  localparam int CW     = $clog2(MAX_V + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cntNext;
  logic [CW-1:0] ponTarget;
  logic          cntAtMax;

  assign reqEff    = calPin | (extMode & calBit);
  assign cntAtMax  = (cnt == {CW{1'b1}});
  assign ponTarget = ponDelaySel ? CW'(PON_LONG - 1) : CW'(PON_SHORT - 1);

  assign lowMet  = (cnt >= CW'(LOW_MIN));
  assign highMet = ((cnt + CW'(1)) >= CW'(HIGH_MIN));
  assign runDone = (cnt == CW'(RUN_CYCLES - 1));
  assign ponDone = (cnt == ponTarget);

  always_comb begin
    cntNext = cnt;
    if (ctl.cntClear) begin
      cntNext = '0;
    end else if (ctl.cntLoadOne) begin
      cntNext = CW'(1);
    end else if (ctl.cntInc && !cntAtMax) begin
      cntNext = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      cnt <= cntNext;
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl == 3'b001 && cntAtMax) |=> cntAtMax); // R1

  AST_EXT_BIT_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && calBit) |-> reqEff); // R6

  AST_CTL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl)); // R4

endmodule

// File: rtl/cal_qual_fsm.sv
module cal_qual_fsm
  import cal_qual_pkg::*;
#(
  parameter int HIGH_MIN = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqEff,
  input  logic    powerGood,
  input  logic    lowMet,
  input  logic    highMet,
  input  logic    runDone,
  input  logic    ponDone,
  output cntCtl_t ctl,
  output logic    calRunning
);

  localparam bit DIRECT_START = (HIGH_MIN <= 1);

  calState_t state;
  calState_t stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_PON_DELAY: begin
        if (!powerGood) begin
          ctl.cntClear = 1'b1;
        end else if (ponDone) begin
          stateNext    = ST_RUN;
          ctl.cntClear = 1'b1;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_IDLE: begin
        if (!reqEff) begin
          stateNext      = ST_WAIT_LOW;
          ctl.cntLoadOne = 1'b1;
        end else begin
          ctl.cntClear = 1'b1;
        end
      end
      ST_WAIT_LOW: begin
        if (!reqEff) begin
          ctl.cntInc = 1'b1;
        end else if (!lowMet) begin
          stateNext    = ST_IDLE;
          ctl.cntClear = 1'b1;
        end else if (DIRECT_START) begin
          stateNext    = ST_RUN;
          ctl.cntClear = 1'b1;
        end else begin
          stateNext      = ST_WAIT_HIGH;
          ctl.cntLoadOne = 1'b1;
        end
      end
      ST_WAIT_HIGH: begin
        if (!reqEff) begin
          stateNext      = ST_WAIT_LOW;
          ctl.cntLoadOne = 1'b1;
        end else if (highMet) begin
          stateNext    = ST_RUN;
          ctl.cntClear = 1'b1;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_RUN: begin
        if (runDone) begin
          stateNext    = ST_IDLE;
          ctl.cntClear = 1'b1;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      default: begin
        stateNext    = ST_IDLE;
        ctl.cntClear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_PON_DELAY;
    end else begin
      state <= stateNext;
    end
  end

  assign calRunning = (state == ST_RUN);

  AST_SHORT_LOW_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_LOW && reqEff && !lowMet) |=> (state == ST_IDLE)); // R1

  AST_START_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calRunning) |-> ($past(reqEff) || $past(state == ST_PON_DELAY))); // R2

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !runDone) |=> calRunning); // R5

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && runDone) |=> !calRunning); // R4

  AST_PON_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_PON_DELAY) |=> (state != ST_PON_DELAY)); // R7

endmodule

// File: rtl/cal_start_qualifier.sv
module cal_start_qualifier
  import cal_qual_pkg::*;
#(
  parameter int LOW_MIN    = 4,
  parameter int HIGH_MIN   = 3,
  parameter int RUN_CYCLES = 10,
  parameter int PON_SHORT  = 5,
  parameter int PON_LONG   = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic calPin,
  input  logic calBit,
  input  logic extMode,
  input  logic powerGood,
  input  logic ponDelaySel,
  output logic calRunning
);

  cntCtl_t ctl;
  logic    reqEff;
  logic    lowMet;
  logic    highMet;
  logic    runDone;
  logic    ponDone;

  cal_qual_count #(
    .LOW_MIN   (LOW_MIN),
    .HIGH_MIN  (HIGH_MIN),
    .RUN_CYCLES(RUN_CYCLES),
    .PON_SHORT (PON_SHORT),
    .PON_LONG  (PON_LONG)
  ) i_count (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .calPin     (calPin),
    .calBit     (calBit),
    .extMode    (extMode),
    .ponDelaySel(ponDelaySel),
    .reqEff     (reqEff),
    .lowMet     (lowMet),
    .highMet    (highMet),
    .runDone    (runDone),
    .ponDone    (ponDone)
  );

  cal_qual_fsm #(
    .HIGH_MIN(HIGH_MIN)
  ) i_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqEff    (reqEff),
    .powerGood (powerGood),
    .lowMet    (lowMet),
    .highMet   (highMet),
    .runDone   (runDone),
    .ponDone   (ponDone),
    .ctl       (ctl),
    .calRunning(calRunning)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !calRunning); // R8

endmodule

// File: tb/test_cal_start_qualifier.sv
`timescale 1ns/1ps
module test_cal_start_qualifier;

  localparam int LOW  = 4;
  localparam int HIGH = 3;
  localparam int RUNC = 10;
  localparam int PS   = 5;
  localparam int PL   = 12;

  logic clk = 1'b0;
  logic rstN, calPin, calBit, extMode, powerGood, ponDelaySel;
  logic calRunning;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  cal_start_qualifier #(
    .LOW_MIN(LOW), .HIGH_MIN(HIGH), .RUN_CYCLES(RUNC),
    .PON_SHORT(PS), .PON_LONG(PL)
  ) i_cal_start_qualifier (
    .clk(clk), .rstN(rstN), .calPin(calPin), .calBit(calBit),
    .extMode(extMode), .powerGood(powerGood), .ponDelaySel(ponDelaySel),
    .calRunning(calRunning)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // set levels at a falling edge, then let n rising edges sample them
  task automatic hold(input logic p, input logic b, input int n);
    calPin = p;
    calBit = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic sel, input logic pg);
    rstN = 1'b0; ponDelaySel = sel; powerGood = pg;
    calPin = 1'b1; calBit = 1'b0; extMode = 1'b0;
    repeat (3) @(negedge clk);
    check(calRunning, 1'b0, "R8", "running during reset");
    rstN = 1'b1;
  endtask

  // calRunning has just risen; it must last RUNC cycles
  task automatic runOut(input string req);
    hold(calPin, calBit, RUNC - 1);
    check(calRunning, 1'b1, req, "still running at last run cycle");
    hold(calPin, calBit, 1);
    check(calRunning, 1'b0, req, "running cleared after RUN_CYCLES");
  endtask

  task automatic testPowerOnShort();
    doReset(1'b0, 1'b0);
    hold(1'b1, 1'b0, 3);
    check(calRunning, 1'b0, "R7", "no start without powerGood");
    powerGood = 1'b1;
    hold(1'b1, 1'b0, PS - 1);
    check(calRunning, 1'b0, "R7", "short delay not yet elapsed");
    hold(1'b1, 1'b0, 1);
    check(calRunning, 1'b1, "R7", "power-on start after short delay");
    runOut("R4");
    hold(1'b1, 1'b0, 30);
    check(calRunning, 1'b0, "R7", "power-on calibration not repeated");
  endtask

  task automatic testPinStart();
    hold(1'b0, 1'b0, LOW);
    hold(1'b1, 1'b0, HIGH - 1);
    check(calRunning, 1'b0, "R2", "one high cycle short of start");
    hold(1'b1, 1'b0, 1);
    check(calRunning, 1'b1, "R2", "start after HIGH_MIN high cycles");
    runOut("R4");
  endtask

  task automatic testShortLow();
    hold(1'b0, 1'b0, LOW - 1);
    hold(1'b1, 1'b0, HIGH + 5);
    check(calRunning, 1'b0, "R1", "low interval one cycle short");
  endtask

  task automatic testBrokenHigh();
    hold(1'b0, 1'b0, LOW);
    hold(1'b1, 1'b0, HIGH - 1);
    hold(1'b0, 1'b0, 1);
    hold(1'b1, 1'b0, HIGH + 3);
    check(calRunning, 1'b0, "R2", "high broken early needs new low interval");
    testPinStart();
  endtask

  task automatic testIgnoredDuringRun();
    hold(1'b0, 1'b0, LOW);
    hold(1'b1, 1'b0, HIGH);
    check(calRunning, 1'b1, "R5", "run started");
    hold(1'b0, 1'b0, RUNC - 1);
    check(calRunning, 1'b1, "R5", "low request during run ignored");
    hold(1'b1, 1'b0, 1);
    check(calRunning, 1'b0, "R4", "run length unchanged by request");
    hold(1'b1, 1'b0, HIGH + 4);
    check(calRunning, 1'b0, "R5", "low cycles during run not counted");
  endtask

  task automatic testModeBits();
    extMode = 1'b0;
    hold(1'b0, 1'b1, LOW);
    hold(1'b1, 1'b1, HIGH);
    check(calRunning, 1'b1, "R3", "bit ignored outside extended mode");
    runOut("R4");
    extMode = 1'b1;
    hold(1'b0, 1'b0, LOW);
    hold(1'b0, 1'b1, HIGH);
    check(calRunning, 1'b1, "R3", "register bit starts in extended mode");
    runOut("R4");
    hold(1'b0, 1'b1, LOW + 2);
    hold(1'b1, 1'b1, HIGH + 2);
    check(calRunning, 1'b0, "R6", "pin sequence blocked by held bit");
    hold(1'b0, 1'b0, LOW);
    hold(1'b1, 1'b0, HIGH);
    check(calRunning, 1'b1, "R6", "start once pin and bit both low");
    runOut("R4");
    extMode = 1'b0;
  endtask

  task automatic testPowerOnLong();
    doReset(1'b1, 1'b1);
    hold(1'b0, 1'b0, PL - 1);
    check(calRunning, 1'b0, "R7", "long delay not yet elapsed");
    hold(1'b0, 1'b0, 1);
    check(calRunning, 1'b1, "R7", "power-on start after long delay");
    runOut("R4");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    rstN = 1'b0; calPin = 1'b1; calBit = 1'b0; extMode = 1'b0;
    powerGood = 1'b0; ponDelaySel = 1'b0;
    @(negedge clk);
    testPowerOnShort();
    testPinStart();
    testShortLow();
    testBrokenHigh();
    testIgnoredDuringRun();
    testModeBits();
    testPowerOnLong();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      summary();
      $finish;
    end
  end

endmodule